// File: doc/BRIEF.md
# Configurable single-port block RAM

This block is a synchronous single-port RAM with a fixed storage budget of 9,216 bits. The word width is a parameter, and the depth and the address width follow from it. Narrow shapes (1, 2 and 4 bits) use 8,192 bits of the budget. The 9, 18 and 36 bit shapes use all of it. One address port serves both reads and writes. A write takes effect on the rising clock edge when the clock enable is high, the write enable is high and the chip-select input matches the instance's decode value.

The behaviour of the data output on a write cycle is chosen at build time. It can keep its previous value, show the word being written, or show the word the write replaces. An optional second output register adds one cycle of latency. A parameter selects whether reset acts asynchronously or on the clock edge. Reset clears the output registers only and leaves the stored words untouched.

Up to eight instances can share one address space. The 3-bit chip-select bus then carries the upper address bits, and each instance gets its own decode value.

Top module: `bram_sp_top`

## Requirements
- R1: Width 1, 2 or 4 gives a depth of 8192/width. Width 9, 18 or 36 gives a depth of 9216/width. The address is ceil(log2(depth)) bits wide, and every address from 0 to depth-1, including the highest, selects its own word.
- R2: A read cycle has clock enable high, chip select equal to the decode value, write enable low and reset low. With the output register absent, dout shows the word at the presented address after the next rising edge, including a word written in the cycle just before.
- R3: With the output register present, the read data of a selected cycle reaches dout one selected cycle later than in R2. The second register advances only on selected cycles.
- R4: In normal write mode, dout keeps its previous value during a selected write.
- R5: In write-through mode, after a selected write the first-stage read register holds the written word. That word then reaches dout, directly or through the output register.
- R6: In read-before-write mode, a selected write loads the first-stage read register with the word the address held before the write.
- R7: A cycle with clock enable low, or with chip select different from the decode value, writes nothing and leaves dout unchanged on the next edge.
- R8: While reset is high, both output registers are zero and no write takes place. With asynchronous reset they clear as soon as reset rises. With synchronous reset they clear on the next rising edge.
- R9: Stored words survive any number of reset cycles unchanged and can be read back after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Active-high reset of the output registers |
| ce | input | 1 | Active-high clock enable |
| we | input | 1 | Active-high write enable |
| cs | input | 3 | Chip select, compared with the CS_MATCH parameter |
| addr | input | AW | Word address, AW derived from DATA_W |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |

## Verification
The properties assume that every input, including reset, is stable around each rising edge. They also assume that reset in asynchronous mode rises and falls away from the clock edge, so that the edge after it falls still sees cleared registers. The back-to-back read-after-write and read-before-write properties assume the address compare uses the full address width. They exclude the cycle right after reset by looking at the previous reset level. The stimulus changes every input just after the falling edge. It raises reset either at that point or, for the asynchronous clear check, halfway to the next edge. Four instances with different widths, write modes, register options, reset styles and decode values share one stimulus stream, so cycles that select one instance leave the others deselected.

// File: rtl/bram_pkg.sv
package bram_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL  = 2'd0,
        WM_THROUGH = 2'd1,
        WM_OLD     = 2'd2
    } wmode_e;

    typedef enum logic {
        OM_NONE = 1'b0,
        OM_PIPE = 1'b1
    } omode_e;

    typedef enum logic {
        RS_ASYNC = 1'b0,
        RS_SYNC  = 1'b1
    } rstyle_e;

    typedef struct packed {
        logic sel;
        logic wr;
    } cyc_ctl_t;

    localparam int TOTAL_BITS  = 9216;
    localparam int BINARY_BITS = 8192;

    function automatic int depth_of(input int w);
        if (w == 9 || w == 18 || w == 36)
            return TOTAL_BITS / w;
        return BINARY_BITS / w;
    endfunction

    function automatic int aw_of(input int w);
        return $clog2(depth_of(w));
    endfunction

endpackage

// File: rtl/bram_sp_store.sv
module bram_sp_store #(
    parameter int W     = 9,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[addr] <= wdata;
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/bram_sp_dreg.sv
module bram_sp_dreg
    import bram_pkg::*;
#(
    parameter int      W      = 9,
    parameter rstyle_e RSTYLE = RS_ASYNC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (RSTYLE == RS_ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst) begin
                if (rst)
                    q <= '0;
                else if (en)
                    q <= d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (en)
                    q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/bram_sp_rdsel.sv
module bram_sp_rdsel
    import bram_pkg::*;
#(
    parameter int     W     = 9,
    parameter wmode_e WMODE = WM_NORMAL
) (
    input  cyc_ctl_t     ctl,
    input  logic [W-1:0] rd_word,
    input  logic [W-1:0] wr_word,
    output logic         load,
    output logic [W-1:0] nxt
);

    localparam logic HOLD_ON_WR = (WMODE == WM_NORMAL);
    localparam logic PASS_WR    = (WMODE == WM_THROUGH);

    always_comb begin
        load = ctl.sel & ~(ctl.wr & HOLD_ON_WR);
        nxt  = (ctl.wr & PASS_WR) ? wr_word : rd_word;
    end

endmodule

// File: rtl/bram_sp_top.sv
module bram_sp_top
    import bram_pkg::*;
#(
    parameter int       DATA_W   = 9,
    parameter wmode_e   WMODE    = WM_NORMAL,
    parameter omode_e   OMODE    = OM_NONE,
    parameter rstyle_e  RSTYLE   = RS_ASYNC,
    parameter logic [2:0] CS_MATCH = 3'd0,
    localparam int      DEPTH    = depth_of(DATA_W),
    localparam int      AW       = aw_of(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              we,
    input  logic [2:0]        cs,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    cyc_ctl_t          ctl;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] stage_d;
    logic [DATA_W-1:0] stage_q;
    logic              stage_ld;

    always_comb begin
        ctl.sel = ce & (cs == CS_MATCH) & ~rst;
        ctl.wr  = ctl.sel & we;
    end

    bram_sp_store #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) store_i (
        .clk   (clk),
        .wr_en (ctl.wr),
        .addr  (addr),
        .wdata (din),
        .rdata (rd_word)
    );

    bram_sp_rdsel #(.W(DATA_W), .WMODE(WMODE)) rdsel_i (
        .ctl     (ctl),
        .rd_word (rd_word),
        .wr_word (din),
        .load    (stage_ld),
        .nxt     (stage_d)
    );

    bram_sp_dreg #(.W(DATA_W), .RSTYLE(RSTYLE)) stage_i (
        .clk (clk),
        .rst (rst),
        .en  (stage_ld),
        .d   (stage_d),
        .q   (stage_q)
    );

    generate
        if (OMODE == OM_PIPE) begin : g_pipe
            bram_sp_dreg #(.W(DATA_W), .RSTYLE(RSTYLE)) out_i (
                .clk (clk),
                .rst (rst),
                .en  (ctl.sel),
                .d   (stage_q),
                .q   (dout)
            );
        end else begin : g_direct
            assign dout = stage_q;
        end
    endgenerate

    // R7: a deselected or disabled cycle leaves the port unchanged
    p_hold_unsel_r7: assert property (@(posedge clk) disable iff (rst)
        !(ce && cs == CS_MATCH) |=> $stable(dout));

    // R8: leaving reset, both register stages still read zero
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stage_q == '0 && dout == '0));

    generate
        if (OMODE == OM_NONE) begin : g_raw_chk
            // R2: reading the address written just before returns the new word
            p_raw_r2: assert property (@(posedge clk) disable iff (rst)
                (ce && cs == CS_MATCH && !we && $past(!rst)
                 && $past(ce && cs == CS_MATCH && we) && addr == $past(addr))
                |=> dout == $past(din, 2));
        end
        if (WMODE == WM_NORMAL) begin : g_norm_chk
            // R4: a write leaves the read register untouched
            p_norm_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (ce && cs == CS_MATCH && we) |=> $stable(stage_q));
        end
        if (WMODE == WM_THROUGH) begin : g_wt_chk
            // R5: the written word lands in the read register
            p_wt_data_r5: assert property (@(posedge clk) disable iff (rst)
                (ce && cs == CS_MATCH && we) |=> stage_q == $past(din));
        end
        if (WMODE == WM_OLD) begin : g_old_chk
            // R6: writing the address just read keeps the word read before
            p_old_word_r6: assert property (@(posedge clk) disable iff (rst)
                (ce && cs == CS_MATCH && we && $past(!rst)
                 && $past(ce && cs == CS_MATCH && !we) && addr == $past(addr))
                |=> $stable(stage_q));
        end
    endgenerate

endmodule

// File: tb/bram_sp_top_tb_top.sv
`timescale 1ns/1ps
module bram_sp_top_tb_top;
    import bram_pkg::*;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce  = 1'b0;
    logic        we  = 1'b0;
    logic [2:0]  cs  = 3'd0;
    logic [12:0] a   = '0;
    logic [35:0] d   = '0;

    always #4 clk = ~clk;

    logic [8:0]  do0;
    logic [3:0]  do1;
    logic [35:0] do2;
    logic [0:0]  do3;
    logic [35:0] dq [N];

    assign dq[0] = {27'd0, do0};
    assign dq[1] = {32'd0, do1};
    assign dq[2] = do2;
    assign dq[3] = {35'd0, do3};

    bram_sp_top #(.DATA_W(9), .WMODE(WM_NORMAL), .OMODE(OM_NONE),
                  .RSTYLE(RS_ASYNC), .CS_MATCH(3'd0)) dut_i (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .cs(cs),
        .addr(a[9:0]), .din(d[8:0]), .dout(do0));

    bram_sp_top #(.DATA_W(4), .WMODE(WM_THROUGH), .OMODE(OM_PIPE),
                  .RSTYLE(RS_SYNC), .CS_MATCH(3'd5)) dut_wt_i (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .cs(cs),
        .addr(a[10:0]), .din(d[3:0]), .dout(do1));

    bram_sp_top #(.DATA_W(36), .WMODE(WM_OLD), .OMODE(OM_PIPE),
                  .RSTYLE(RS_ASYNC), .CS_MATCH(3'd3)) dut_old_i (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .cs(cs),
        .addr(a[7:0]), .din(d), .dout(do2));

    bram_sp_top #(.DATA_W(1), .WMODE(WM_OLD), .OMODE(OM_NONE),
                  .RSTYLE(RS_SYNC), .CS_MATCH(3'd7)) dut_bit_i (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .cs(cs),
        .addr(a[12:0]), .din(d[0]), .dout(do3));

    int         pw    [N] = '{9, 4, 36, 1};
    int         paw   [N] = '{10, 11, 8, 13};
    int         pmode [N] = '{0, 1, 2, 2};
    bit         ppipe [N] = '{0, 1, 1, 0};
    bit         pasync[N] = '{1, 0, 1, 0};
    logic [2:0] pcs   [N] = '{3'd0, 3'd5, 3'd3, 3'd7};

    logic [35:0] mm [int];
    logic [35:0] q0 [N];
    logic [35:0] q1 [N];
    bit          k0 [N];
    bit          k1 [N];
    string       tg [N];
    string       force_tag = "";

    int checks = 0;
    int fails  = 0;

    function automatic logic [35:0] wmask(input int w);
        return (w >= 36) ? 36'hF_FFFF_FFFF : ((36'd1 << w) - 36'd1);
    endfunction

    function automatic int amask(input int aw);
        return (1 << aw) - 1;
    endfunction

    task automatic step();
        for (int i = 0; i < N; i++) begin
            int          key;
            logic [35:0] old;
            bit          oldk;
            logic [35:0] nq;
            bit          nk;
            key = i * 16384 + (int'(a) & amask(paw[i]));
            if (rst) begin
                q0[i] = '0; q1[i] = '0; k0[i] = 1; k1[i] = 1;
                tg[i] = "R8";
            end else if (ce && cs == pcs[i]) begin
                oldk = mm.exists(key);
                old  = oldk ? mm[key] : '0;
                nq = old; nk = oldk;
                if (we) begin
                    mm[key] = d & wmask(pw[i]);
                    if (pmode[i] == 0) begin
                        nq = q0[i]; nk = k0[i]; tg[i] = "R4";
                    end else if (pmode[i] == 1) begin
                        nq = d & wmask(pw[i]); nk = 1; tg[i] = "R5";
                    end else begin
                        tg[i] = "R6";
                    end
                end else begin
                    tg[i] = ppipe[i] ? "R3" : "R2";
                end
                q1[i] = q0[i]; k1[i] = k0[i];
                q0[i] = nq;    k0[i] = nk;
            end else begin
                tg[i] = "R7";
            end
        end
    endtask

    task automatic check_one(input int i, input string t,
                             input logic [35:0] exp);
        checks++;
        if (dq[i] !== exp) begin
            fails++;
            $display("FAIL %s inst%0d: dout=%h expected %h", t, i, dq[i], exp);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < N; i++) begin
            logic [35:0] exp;
            bit          kn;
            exp = ppipe[i] ? q1[i] : q0[i];
            kn  = ppipe[i] ? k1[i] : k0[i];
            if (kn)
                check_one(i, (force_tag != "") ? force_tag : tg[i], exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        step();
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(input bit c, input bit w, input logic [2:0] s,
                         input logic [12:0] ad, input logic [35:0] dt);
        ce = c; we = w; cs = s; a = ad; d = dt;
        cyc();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            q0[i] = '0; q1[i] = '0; k0[i] = 0; k1[i] = 0; tg[i] = "R8";
        end
        rst = 1'b1;
        // R8: outputs are zero during reset
        force_tag = "R8";
        for (int c = 0; c < 3; c++) cyc();
        @(negedge clk);
        rst = 1'b0;
        force_tag = "";

        // R1: highest and lowest addresses of each shape are separate words
        force_tag = "R1";
        for (int i = 0; i < N; i++) begin
            drive(1, 1, pcs[i], 13'h1FFF, 36'hA_5A5A_5A5A ^ 36'(i));
            drive(1, 1, pcs[i], 13'h0000, 36'h5_A5A5_A5A5 + 36'(i));
            drive(1, 0, pcs[i], 13'h1FFF, 36'd0);
            drive(1, 0, pcs[i], 13'h0000, 36'd0);
            drive(1, 0, pcs[i], 13'h0000, 36'd0);
        end
        force_tag = "";

        // R7: clock enable low with a matching select writes nothing
        for (int i = 0; i < N; i++)
            drive(0, 1, pcs[i], 13'h0000, 36'h0_FFFF_0000);
        force_tag = "R7";
        for (int i = 0; i < N; i++) begin
            drive(1, 0, pcs[i], 13'h0000, 36'd0);
            drive(1, 0, pcs[i], 13'h0000, 36'd0);
        end
        force_tag = "";

        // R8: asynchronous instances clear before the next edge
        drive(1, 0, 3'd3, 13'h1FFF, 36'd0);
        drive(1, 0, 3'd0, 13'h1FFF, 36'd0);
        #2;
        rst = 1'b1;
        #1;
        for (int i = 0; i < N; i++) begin
            if (pasync[i]) begin
                check_one(i, "R8", 36'd0);
                q0[i] = '0; q1[i] = '0; k0[i] = 1; k1[i] = 1;
            end
        end
        cyc();
        @(negedge clk);
        rst = 1'b0;

        // R9: a stored word survives reset
        for (int i = 0; i < N; i++)
            drive(1, 1, pcs[i], 13'h0005, 36'h3_1234_5678 ^ {4{9'(i)}});
        rst = 1'b1;
        force_tag = "R8";
        for (int c = 0; c < 3; c++) drive(1, 1, pcs[0], 13'h0005, 36'd0);
        rst = 1'b0;
        force_tag = "R9";
        for (int i = 0; i < N; i++) begin
            drive(1, 0, pcs[i], 13'h0005, 36'd0);
            drive(1, 0, pcs[i], 13'h0005, 36'd0);
        end
        force_tag = "";

        // Random mix over all instances and modes
        for (int c = 0; c < 4000; c++) begin
            logic [2:0]  s;
            logic [12:0] ad;
            int          r;
            r  = int'($urandom % 100);
            s  = (r < 85) ? pcs[$urandom % N] : 3'($urandom);
            ad = ($urandom % 2 == 0) ? 13'($urandom % 16)
                                     : 13'(13'h1FFF - 13'($urandom % 16));
            rst = ($urandom % 100 == 0);
            drive(($urandom % 10) != 0, ($urandom % 10) < 4, s, ad,
                  {4'($urandom), 32'($urandom)});
        end
        rst = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule